// File: doc/BRIEF.md
# Nibble Accumulator Datapath with Carry/Zero Flags

This block is the arithmetic core of a small 4-bit processor. One operand of its arithmetic unit is always the accumulator register. The other is a nibble taken from the data bus, which carries either an immediate constant or a value read from data memory. The unit computes a result combinationally and presents it on `alu_res`, which the surrounding machine drives onto the bus for stores and output-port writes. On the clock edge the block can optionally copy that result into the accumulator and, separately, capture carry and zero flags.

The sequencer supplies the carry-in for every operation, and the stored carry flag is never routed back into the adder. A multi-nibble sum therefore needs software to test the carry and add the extra one itself. A compare is the subtract operation with carry-in set to 1 and the accumulator write disabled, so only the flags change. The only logic function is NOR. Two pass modes forward either the accumulator or the bus operand. The first lets the accumulator drive the bus. The second loads literals, memory reads and input-port reads without touching the flags.

Top module: `nib_acc_datapath`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the accumulator is 0 and both flags are 0.
- R2: With op_sel = 3'd2 (add), alu_res equals (acc + operand + carry_in) mod 16, combinationally.
- R3: When flag_load is high at a clock edge during add, flag_c takes the carry-out of bit 3 of that sum.
- R4: With op_sel = 3'd3 (subtract), alu_res equals (acc + ~operand + carry_in) mod 16. The flag_c captured during subtract is that carry-out, so with carry_in = 1, flag_c = 1 means acc >= operand (no borrow).
- R5: A compare (subtract with carry_in = 1, acc_load = 0, flag_load = 1) updates both flags and leaves the accumulator unchanged.
- R6: With op_sel = 3'd4 (NOR), alu_res equals ~(acc | operand). When flags are loaded during NOR, flag_c becomes 0.
- R7: When flag_load is high at a clock edge, flag_z becomes 1 exactly when alu_res is 0 in that cycle.
- R8: When flag_load is low at a clock edge, flag_c and flag_z keep their values.
- R9: When acc_load is low at a clock edge, the accumulator keeps its value. When acc_load is high, it takes alu_res.
- R10: The stored carry flag has no effect on any result. With flag_c = 1 and carry_in = 0, add produces acc + operand with no extra 1.
- R11: op_sel = 3'd0 gives alu_res = acc, and op_sel = 3'd1 gives alu_res = operand. Codes 5 to 7 behave as 3'd0. In the pass modes, loaded flags take C = 0 and Z = (alu_res == 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 3 | Operation: 0 pass acc, 1 pass operand, 2 add, 3 subtract, 4 NOR |
| carry_in | input | 1 | Carry-in supplied by the sequencer |
| acc_load | input | 1 | Write alu_res into the accumulator at the clock edge |
| flag_load | input | 1 | Capture carry and zero at the clock edge |
| operand | input | 4 | Data-bus operand |
| acc | output | 4 | Accumulator value |
| alu_res | output | 4 | Combinational result of the unit |
| flag_c | output | 1 | Stored carry flag |
| flag_z | output | 1 | Stored zero flag |

## Verification
A corrupted accumulator shows up on `acc` one edge after the faulty load. In pass-acc mode it also shows up at once on `alu_res`. A bad carry chain appears on `alu_res` in the same cycle, and on `flag_c` after the next edge if the flags are loaded. A flag register that leaks updates when it should hold, or a carry flag that feeds back into the adder, can only be seen one edge later. For that reason the bench checks the flags and the accumulator after every step against a model that it keeps itself.

// File: rtl/nib_acc_pkg.sv
package nib_acc_pkg;
    typedef enum logic [2:0] {
        OP_PASS_ACC = 3'd0,
        OP_PASS_OPD = 3'd1,
        OP_ADD      = 3'd2,
        OP_SUB      = 3'd3,
        OP_NOR      = 3'd4
    } alu_op_e;
endpackage

// File: rtl/nib_adder.sv
module nib_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         invert_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0]   chain;
    logic [W-1:0] b_eff;

    assign chain[0] = cin;
    assign b_eff    = invert_b ? ~b_in : b_in;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a_in[i] ^ b_eff[i] ^ chain[i];
        assign chain[i+1] = (a_in[i] & b_eff[i]) | (chain[i] & (a_in[i] ^ b_eff[i]));
    end

    assign cout = chain[W];
endmodule

// File: rtl/nib_alu_unit.sv
module nib_alu_unit
    import nib_acc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [2:0]   op_sel,
    input  logic         carry_in,
    input  logic [W-1:0] acc_val,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] result,
    output logic         carry_out
);
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         is_sub;

    assign is_sub = (op_sel == OP_SUB);

    nib_adder #(.W(W)) u_add (
        .a_in     (acc_val),
        .b_in     (opnd),
        .invert_b (is_sub),
        .cin      (carry_in),
        .sum      (add_sum),
        .cout     (add_cout)
    );

    always_comb begin
        result    = acc_val;
        carry_out = 1'b0;
        case (op_sel)
            OP_PASS_OPD: result = opnd;
            OP_ADD, OP_SUB: begin
                result    = add_sum;
                carry_out = add_cout;
            end
            OP_NOR:      result = ~(acc_val | opnd);
            default:     result = acc_val;
        endcase
    end

    always_comb begin
        if (op_sel == OP_NOR) begin
            a_nor_nocarry_r6: assert (carry_out == 1'b0);
        end
    end
endmodule

// File: rtl/nib_acc_datapath.sv
module nib_acc_datapath
    import nib_acc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op_sel,
    input  logic         carry_in,
    input  logic         acc_load,
    input  logic         flag_load,
    input  logic [W-1:0] operand,
    output logic [W-1:0] acc,
    output logic [W-1:0] alu_res,
    output logic         flag_c,
    output logic         flag_z
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic         c;
        logic         z;
    } dp_state_t;

    dp_state_t st_d, st_q;
    logic      unit_cout;

    nib_alu_unit #(.W(W)) u_alu (
        .op_sel    (op_sel),
        .carry_in  (carry_in),
        .acc_val   (st_q.acc),
        .opnd      (operand),
        .result    (alu_res),
        .carry_out (unit_cout)
    );

    always_comb begin
        st_d = st_q;
        if (acc_load) begin
            st_d.acc = alu_res;
        end
        if (flag_load) begin
            st_d.c = unit_cout;
            st_d.z = (alu_res == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc    = st_q.acc;
    assign flag_c = st_q.c;
    assign flag_z = st_q.z;

    p_acc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_load |=> $stable(acc));
    p_acc_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_load |=> (acc == $past(alu_res)));
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_load |=> ($stable(flag_c) && $stable(flag_z)));
    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> (flag_z == ($past(alu_res) == '0)));
    p_nor_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && op_sel == OP_NOR) |=> !flag_c);
    p_cmp_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SUB && !acc_load) |=> $stable(acc));
endmodule

// File: tb/nib_acc_datapath_test.sv
module nib_acc_datapath_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_sel = 3'd0;
    logic         carry_in = 1'b0;
    logic         acc_load = 1'b0;
    logic         flag_load = 1'b0;
    logic [W-1:0] operand = '0;
    logic [W-1:0] acc, alu_res;
    logic         flag_c, flag_z;

    int n_run = 0;
    int n_fail = 0;
    logic [W-1:0] m_acc;
    logic         m_c, m_z;

    always #4 clk = ~clk;

    nib_acc_datapath #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .carry_in(carry_in),
        .acc_load(acc_load), .flag_load(flag_load), .operand(operand),
        .acc(acc), .alu_res(alu_res), .flag_c(flag_c), .flag_z(flag_z)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [W:0] ref_res(input logic [2:0] op, input logic ci,
                                           input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        case (op)
            3'd1: s = {1'b0, b};
            3'd2: s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
            3'd3: s = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, ci};
            3'd4: s = {1'b0, ~(a | b)};
            default: s = {1'b0, a};
        endcase
        return s;
    endfunction

    // Drive on the falling edge, check alu_res, clock, then check state.
    task automatic step(input string req, input logic [2:0] op, input logic ci,
                        input logic al, input logic fl, input logic [W-1:0] b);
        logic [W:0] r;
        @(negedge clk);
        op_sel = op; carry_in = ci; acc_load = al; flag_load = fl; operand = b;
        #1;
        r = ref_res(op, ci, m_acc, b);
        chk(req, "alu_res", alu_res, r[W-1:0]);
        if (al) m_acc = r[W-1:0];
        if (fl) begin
            m_c = r[W];
            m_z = (r[W-1:0] == '0);
        end
        @(posedge clk);
        #1;
        chk(req, "acc", acc, m_acc);
        chk(req, "flag_c", flag_c, m_c);
        chk(req, "flag_z", flag_z, m_z);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        m_acc = '0; m_c = 1'b0; m_z = 1'b0;
        chk("R1", "acc", acc, 0);
        chk("R1", "flag_c", flag_c, 0);
        chk("R1", "flag_z", flag_z, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_pass;
        step("R11", 3'd1, 1'b0, 1'b1, 1'b0, 4'd7);
        chk("R11", "acc after literal", acc, 7);
        step("R11", 3'd0, 1'b0, 1'b0, 1'b0, 4'd2);
        chk("R11", "pass acc", alu_res, 7);
        step("R11", 3'd6, 1'b1, 1'b0, 1'b0, 4'd9);
        chk("R11", "code 6 as pass acc", alu_res, 7);
        step("R11", 3'd1, 1'b0, 1'b1, 1'b1, 4'd0);
        chk("R11", "pass zero flag", flag_z, 1);
        step("R11", 3'd1, 1'b0, 1'b1, 1'b0, 4'd7);
    endtask

    task automatic t_add;
        step("R2", 3'd2, 1'b0, 1'b1, 1'b1, 4'd5);
        chk("R3", "12 no carry", flag_c, 0);
        step("R3", 3'd2, 1'b0, 1'b1, 1'b1, 4'd4);
        chk("R3", "wrap carry", flag_c, 1);
        chk("R7", "wrap zero", flag_z, 1);
        step("R10", 3'd2, 1'b0, 1'b1, 1'b1, 4'd3);
        chk("R10", "no feedback", acc, 3);
        step("R2", 3'd2, 1'b1, 1'b1, 1'b1, 4'd3);
        chk("R2", "carry_in adds one", acc, 7);
        step("R2", 3'd2, 1'b1, 1'b1, 1'b1, 4'd8);
        chk("R3", "exact 16 carry", flag_c, 1);
        step("R2", 3'd1, 1'b0, 1'b1, 1'b0, 4'd7);
    endtask

    task automatic t_compare;
        step("R5", 3'd3, 1'b1, 1'b0, 1'b1, 4'd7);
        chk("R5", "acc kept", acc, 7);
        chk("R4", "equal no borrow", flag_c, 1);
        chk("R7", "equal zero", flag_z, 1);
        step("R4", 3'd3, 1'b1, 1'b0, 1'b1, 4'd9);
        chk("R4", "borrow", flag_c, 0);
        step("R4", 3'd3, 1'b1, 1'b0, 1'b1, 4'd2);
        chk("R4", "greater", flag_c, 1);
        step("R4", 3'd3, 1'b0, 1'b1, 1'b1, 4'd2);
        chk("R4", "sub cin0", acc, 4);
    endtask

    task automatic t_nor;
        step("R6", 3'd1, 1'b0, 1'b1, 1'b0, 4'd7);
        step("R6", 3'd4, 1'b0, 1'b1, 1'b1, 4'd8);
        chk("R6", "nor to zero", acc, 0);
        chk("R6", "nor carry", flag_c, 0);
        step("R6", 3'd1, 1'b0, 1'b1, 1'b0, 4'd5);
        step("R6", 3'd4, 1'b1, 1'b1, 1'b1, 4'd2);
        chk("R6", "nor value", acc, 8);
    endtask

    task automatic t_hold;
        step("R8", 3'd2, 1'b0, 1'b1, 1'b1, 4'd8);
        step("R8", 3'd2, 1'b1, 1'b0, 1'b0, 4'd9);
        chk("R9", "acc held", acc, 0);
        chk("R8", "c held", flag_c, 1);
        chk("R8", "z held", flag_z, 1);
        step("R9", 3'd1, 1'b0, 1'b1, 1'b0, 4'd15);
        chk("R8", "flags kept on load", flag_z, 1);
        step("R9", 3'd4, 1'b0, 1'b0, 1'b0, 4'd0);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_add();
        t_compare();
        t_nor();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule